// File: doc/BRIEF.md
# Single-to-Double Floating-Point Widener

This block converts a 32-bit IEEE single-precision word, as delivered by a single-precision floating-point load, into the 64-bit double-precision image held in a floating-point register. Normal numbers, signed zeros, infinities and NaNs are widened by rearranging bits. The top exponent bit of the single is copied or inverted to fill the three new exponent bits, so no adder re-biases the exponent. Single-precision denormals cannot be represented as double denormals with the same meaning, so the block renormalises them into normal doubles. A leading-zero count and a left shift do this in one cycle.

A caller presents the word with `valid_i` high for one cycle. One clock later `done_o` pulses and `result_o` carries the image. `result_o` keeps that value until the next accepted word. Back-to-back words are accepted on every cycle. In the text below, bit numbering is given with the sign as the most significant bit: input bit 31 is the sign, 30..23 the exponent, 22..0 the fraction. Output bit 63 is the sign, 62..52 the exponent, 51..0 the fraction.

Top module: `s2d_widener`

## Requirements
- R1: For a normal input (exponent field neither 0 nor 255), `result_o[63:62]` = `word_i[31:30]`, each of `result_o[61:59]` is the inverse of `word_i[30]`, and `result_o[58:0]` = {`word_i[29:0]`, 29 zero bits}.
- R2: For an input with exponent field 255 (infinity or NaN), `result_o[63:62]` = `word_i[31:30]`, each of `result_o[61:59]` equals `word_i[30]`, and `result_o[58:0]` = {`word_i[29:0]`, 29 zeros}. NaN payload bits therefore pass through unchanged.
- R3: An input whose bits 30..0 are all zero yields `result_o` = {`word_i[31]`, 63 zeros}, so the sign of zero is kept.
- R4: For a denormal input (exponent 0, fraction F nonzero), let L be the number of leading zeros of the 23-bit F, counted from bit 22. `result_o[63]` is the sign and `result_o[62:52]` = 896 − L. This gives 874 for F = 1 and 896 when F[22] is set.
- R5: For a denormal input, `result_o[51:29]` is F shifted left by L+1 places and truncated to 23 bits, so the leading one is dropped. `result_o[28:0]` is zero.
- R6: `done_o` is high in exactly the cycle after each cycle in which `valid_i` is high. `result_o` holds that word's image in the same cycle. Consecutive valid cycles give consecutive results.
- R7: While `valid_i` is low, `word_i` is ignored: `result_o` keeps its last value and `done_o` stays low.
- R8: After synchronous reset (`rst` high at a clock edge), `done_o` is 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Accept `word_i` this cycle |
| word_i | input | 32 | Single-precision word, sign in bit 31 |
| done_o | output | 1 | One-cycle pulse: `result_o` holds a new image |
| result_o | output | 64 | Double-precision image, sign in bit 63 |

## Verification
The bench targets the class boundaries first: exponent 0 against 1 and 254 against 255, and fraction zero against nonzero under exponent 0. A design that uses the wrong class there would invert, instead of copy, the new exponent bits for infinities and NaNs, or would treat the smallest normal as a denormal. Each single-bit denormal fraction is swept across all 23 positions, with the expected exponent worked out from the bit position. An off-by-one in the leading-zero count or the shift would put every result one binade off or keep the hidden one in the fraction. Negative zero, NaN payloads and word changes while `valid_i` is low catch a lost sign, a lost payload, and a register that loads when it should hold.

// File: rtl/s2d_pkg.sv
package s2d_pkg;
  localparam int SGL_W     = 32;
  localparam int SGL_EXP_W = 8;
  localparam int SGL_FRC_W = 23;
  localparam int DBL_W     = 64;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_FRC_W = 52;
  localparam int SGL_BIAS  = 127;
  localparam int DBL_BIAS  = 1023;
  localparam int PAD_W     = DBL_FRC_W - SGL_FRC_W;      // 29
  localparam int XTRA_W    = DBL_EXP_W - SGL_EXP_W;      // 3
  localparam int LZ_W      = $clog2(SGL_FRC_W + 1);      // 5
  localparam int EXP_MAX   = (1 << SGL_EXP_W) - 1;       // 255

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_NORMAL  = 2'd1,
    CLS_DENORM  = 2'd2,
    CLS_SPECIAL = 2'd3
  } fp_class_e;

  // Leading zeros of a fraction, counted from its top bit.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [SGL_FRC_W-1:0] f);
    logic [LZ_W-1:0] n;
    n = LZ_W'(SGL_FRC_W);
    for (int i = 0; i < SGL_FRC_W; i++)
      if (f[i]) n = LZ_W'(SGL_FRC_W - 1 - i);
    return n;
  endfunction

  // Bit rearrangement used for every class except denormals.
  function automatic logic [DBL_W-1:0] remap(input logic [SGL_W-1:0] w,
                                             input logic invert);
    logic top;
    top = invert ? ~w[SGL_W-2] : w[SGL_W-2];
    return {w[SGL_W-1 -: 2], {XTRA_W{top}}, w[SGL_W-3:0], {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/s2d_classify.sv
module s2d_classify
  import s2d_pkg::*;
(
  input  logic [SGL_EXP_W-1:0] exp_i,
  input  logic [SGL_FRC_W-1:0] frc_i,
  output fp_class_e            cls_o
);
  logic exp_zero, exp_ones, frc_zero;
  assign exp_zero = (exp_i == '0);
  assign exp_ones = (exp_i == SGL_EXP_W'(EXP_MAX));
  assign frc_zero = (frc_i == '0);

  always_comb begin
    if (exp_zero && frc_zero) cls_o = CLS_ZERO;
    else if (exp_zero)        cls_o = CLS_DENORM;
    else if (exp_ones)        cls_o = CLS_SPECIAL;
    else                      cls_o = CLS_NORMAL;
  end
endmodule

// File: rtl/s2d_renorm.sv
module s2d_renorm
  import s2d_pkg::*;
(
  input  logic [SGL_FRC_W-1:0] frc_i,
  output logic [LZ_W-1:0]      lz_o,
  output logic [DBL_EXP_W-1:0] exp_o,
  output logic [DBL_FRC_W-1:0] frc_o
);
  localparam int EXP_TOP = DBL_BIAS - SGL_BIAS;   // 896

  logic [SGL_FRC_W-1:0] shifted;

  assign lz_o    = lead_zeros(frc_i);
  // drop the leading one: shift past it by one extra place
  assign shifted = (frc_i << lz_o) << 1;
  assign exp_o   = DBL_EXP_W'(EXP_TOP) - DBL_EXP_W'(lz_o);
  assign frc_o   = {shifted, {PAD_W{1'b0}}};
endmodule

// File: rtl/s2d_widener.sv
module s2d_widener
  import s2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_i,
  input  logic [31:0] word_i,
  output logic        done_o,
  output logic [63:0] result_o
);
  fp_class_e            cls;
  logic [LZ_W-1:0]      lead_z;
  logic [DBL_EXP_W-1:0] dn_exp;
  logic [DBL_FRC_W-1:0] dn_frc;
  logic [DBL_W-1:0]     image;

  s2d_classify u_cls (
    .exp_i (word_i[SGL_W-2 -: SGL_EXP_W]),
    .frc_i (word_i[SGL_FRC_W-1:0]),
    .cls_o (cls)
  );

  s2d_renorm u_renorm (
    .frc_i (word_i[SGL_FRC_W-1:0]),
    .lz_o  (lead_z),
    .exp_o (dn_exp),
    .frc_o (dn_frc)
  );

  always_comb begin
    unique case (cls)
      CLS_DENORM: image = {word_i[SGL_W-1], dn_exp, dn_frc};
      CLS_NORMAL: image = remap(word_i, 1'b1);
      default:    image = remap(word_i, 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) result_o <= image;
    end
  end
endmodule

// File: rtl/s2d_widener_chk.sv
module s2d_widener_chk
  import s2d_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [31:0]     word_i,
  input  logic            done_o,
  input  logic [63:0]     result_o,
  input  fp_class_e       cls,
  input  logic [LZ_W-1:0] lead_z
);
  logic [7:0] ex;
  assign ex = word_i[30:23];

  a_r6_done_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  a_r7_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !done_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(result_o));
  a_r1_normal_invert: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ex != 8'd0 && ex != 8'd255)
      |=> result_o[61:59] == {3{~$past(word_i[30])}});
  a_r2_special_copy: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ex == 8'd255)
      |=> (result_o[61:59] == 3'b111 && result_o[51:29] == $past(word_i[22:0])));
  a_r3_signed_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_i && word_i[30:0] == '0) |=> result_o == {$past(word_i[31]), 63'd0});
  a_r4_denorm_range: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ex == 8'd0 && word_i[22:0] != '0)
      |=> (result_o[62:52] >= 11'd874 && result_o[62:52] <= 11'd896
           && result_o[63] == $past(word_i[31])));
  a_r5_denorm_pad: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ex == 8'd0 && word_i[22:0] != '0) |=> result_o[28:0] == '0);
  a_r4_class_count: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_DENORM) |-> lead_z < LZ_W'(SGL_FRC_W));
  a_r1_class_match: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_NORMAL) |-> (ex != 8'd0 && ex != 8'd255));
endmodule

bind s2d_widener s2d_widener_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_i  (valid_i),
  .word_i   (word_i),
  .done_o   (done_o),
  .result_o (result_o),
  .cls      (cls),
  .lead_z   (lead_z)
);

// File: tb/s2d_widener_bench.sv
`timescale 1ns/1ps
module s2d_widener_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] word_i;
  logic        done_o;
  logic [63:0] result_o;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  s2d_widener u_s2d_widener (
    .clk(clk), .rst(rst), .valid_i(valid_i), .word_i(word_i),
    .done_o(done_o), .result_o(result_o)
  );

  localparam int NV = 14;
  // {requirement tag number, input word, expected image}
  localparam logic [103:0] VEC [NV] = '{
    {8'd1, 32'h42013333, 64'h4040266660000000},
    {8'd1, 32'h3F800000, 64'h3FF0000000000000},
    {8'd1, 32'hC0000000, 64'hC000000000000000},
    {8'd1, 32'h00800000, 64'h3810000000000000},
    {8'd1, 32'h7F7FFFFF, 64'h47EFFFFFE0000000},
    {8'd2, 32'h7F800000, 64'h7FF0000000000000},
    {8'd2, 32'hFF800000, 64'hFFF0000000000000},
    {8'd2, 32'h7FC00001, 64'h7FF8000020000000},
    {8'd3, 32'h80000000, 64'h8000000000000000},
    {8'd3, 32'h00000000, 64'h0000000000000000},
    {8'd4, 32'h00000001, 64'h36A0000000000000},
    {8'd4, 32'h80400000, 64'hB800000000000000},
    {8'd5, 32'h007FFFFF, 64'h380FFFFFC0000000},
    {8'd5, 32'h00000003, 64'h36B8000000000000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word in, result sampled on the following falling edge
  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    valid_i = 1'b1; word_i = w;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; valid_i = 1'b0; word_i = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset done", {63'd0, done_o}, 64'd0);
    check("R8 reset result", result_o, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][95:64]);
      check($sformatf("R%0d vector %h", VEC[i][103:96], VEC[i][95:64]),
            result_o, VEC[i][63:0]);
      check("R6 done pulse", {63'd0, done_o}, 64'd1);
    end

    // R4 R5 single-bit denormal sweep: bit k gives exponent 874+k, empty fraction
    for (int k = 0; k < 23; k++) begin
      apply(32'd1 << k);
      check($sformatf("R4 R5 denormal bit %0d", k), result_o,
            {1'b0, 11'(874 + k), 52'd0});
    end

    // R7 word changes with valid low: nothing moves
    held = result_o;
    @(negedge clk);
    word_i = 32'h12345678;
    @(negedge clk);
    word_i = 32'h7F800000;
    @(negedge clk);
    check("R7 result held", result_o, held);
    check("R7 done low", {63'd0, done_o}, 64'd0);

    // R6 back-to-back words
    @(negedge clk);
    valid_i = 1'b1; word_i = 32'h3F800000;
    @(negedge clk);
    word_i = 32'h80000000;
    check("R6 first of pair", result_o, 64'h3FF0000000000000);
    check("R6 done first", {63'd0, done_o}, 64'd1);
    @(negedge clk);
    valid_i = 1'b0;
    check("R6 second of pair", result_o, 64'h8000000000000000);
    check("R6 done second", {63'd0, done_o}, 64'd1);
    @(negedge clk);
    check("R6 done drops", {63'd0, done_o}, 64'd0);

    // R8 reset clears a loaded result
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset after use", result_o, 64'd0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule